// File: doc/BRIEF.md
# Snoop Channel Network Interface

This block sits between one coherent-bus snoop request channel and the local port of a mesh router. On the send side it takes a snoop request (line address, snoop opcode, protection attributes and transaction tag) through a valid/ready handshake. It then emits the request as a short packet of 32-bit flits. The first flit is a 12-bit routing header: the attached router's own ID as source, a destination router ID taken from a slice of the address, and the master's transaction tag. The payload flits follow it. Begin and end marker bits travel beside the flit data.

On the receive side it takes flits from the router and rebuilds the channel fields from the begin marker up to the end marker. It presents them with a valid signal and holds them until the consumer takes them. Back-pressure rules are the same on every stream: a transfer happens only on a clock edge where both valid and ready are high. A source that raises valid keeps its data stable until the transfer. The send side accepts no new request while a packet is still in flight, and the receive side accepts no flit while a rebuilt request is waiting.

Top module: `snoop_ni`

## Requirements
- R1: After reset `in_ready` and `rx_flit_ready` are 1 and `tx_flit_valid` and `out_valid` are 0.
- R2: Each accepted request leaves as exactly three flits in order: header, address, attributes. `tx_bop` is 1 only on the header flit and `tx_eop` is 1 only on the attributes flit. The header flit is valid in the cycle after the request is accepted.
- R3: The header flit holds the transaction tag in bits [3:0], the destination ID in bits [7:4] and the parameter `NODE_ID` in bits [11:8]. Bits [31:12] are zero.
- R4: The destination ID equals address bits [31:28] (parameter `MAP_LSB` = 28).
- R5: The address flit carries the whole 32-bit address. The attributes flit carries the snoop opcode in bits [3:0] and the protection attributes in bits [6:4], and bits [31:7] are zero.
- R6: `in_ready` is 0 from the cycle after a request is accepted until the last flit has been taken by the router. It is 1 again in the cycle after that.
- R7: While `tx_flit_valid` is 1 and `tx_flit_ready` is 0, the flit data and both markers stay unchanged.
- R8: A received packet (begin flit, address flit, attributes flit with end marker) is presented with `out_valid` in the cycle after its last flit is accepted. The address, opcode, protection, tag, source and destination fields are decoded with the R3/R5 layout.
- R9: While `out_valid` is 1 and `out_ready` is 0, the presented fields stay unchanged and `rx_flit_ready` is 0. `out_valid` falls in the cycle after `out_ready` is seen.
- R10: A flit that arrives outside a packet (no begin marker since the last end marker) is dropped. It raises no `out_valid` and does not alter the next packet.
- R11: A begin marker in the middle of a packet discards the partial packet and starts a new one from that flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Snoop request valid |
| in_ready | output | 1 | Snoop request ready |
| in_addr | input | 32 | Snoop line address |
| in_type | input | 4 | Snoop opcode |
| in_prot | input | 3 | Protection attributes |
| in_tid | input | 4 | Transaction tag from the master |
| tx_flit_valid | output | 1 | Outgoing flit valid |
| tx_flit_ready | input | 1 | Router accepts outgoing flit |
| tx_flit | output | 32 | Outgoing flit data |
| tx_bop | output | 1 | Outgoing flit is first of packet |
| tx_eop | output | 1 | Outgoing flit is last of packet |
| rx_flit_valid | input | 1 | Incoming flit valid |
| rx_flit_ready | output | 1 | Interface accepts incoming flit |
| rx_flit | input | 32 | Incoming flit data |
| rx_bop | input | 1 | Incoming flit is first of packet |
| rx_eop | input | 1 | Incoming flit is last of packet |
| out_valid | output | 1 | Rebuilt request valid |
| out_ready | input | 1 | Consumer takes rebuilt request |
| out_addr | output | 32 | Rebuilt address |
| out_type | output | 4 | Rebuilt snoop opcode |
| out_prot | output | 3 | Rebuilt protection attributes |
| out_tid | output | 4 | Rebuilt transaction tag |
| out_src | output | 4 | Source router ID from header |
| out_dst | output | 4 | Destination router ID from header |

## Verification
The send side is swept over all 256 pairs of transaction tag and destination nibble. Opcode, protection and low address bits are derived arithmetically, so a swapped or shifted field shows up as a mismatch. Per flit, router stalls of zero, one and two cycles are mixed in, which separates correct holding of a stalled flit from skipping or repeating one. Every captured packet is fed back into the receive side and held with the consumer stalled, so the layouts on the two sides must agree with each other and with the computed values. Separate receive-only patterns check the framing cases: stray flits before a begin marker, and a begin marker that cuts off a partial packet.

// File: rtl/ni_pkg.sv
`timescale 1ns/1ps
package ni_pkg;
  localparam int ID_W  = 4;
  localparam int HDR_W = 3 * ID_W;

  // Header layout: source in the top nibble, tag in the bottom nibble.
  typedef struct packed {
    logic [ID_W-1:0] src;
    logic [ID_W-1:0] dst;
    logic [ID_W-1:0] tid;
  } ni_hdr_t;
endpackage

// File: rtl/ni_dest_map.sv
`timescale 1ns/1ps
module ni_dest_map #(
  parameter int ADDR_W  = 32,
  parameter int MAP_LSB = 28
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic [ni_pkg::ID_W-1:0] dst
);
  // The target router is selected by one address slice.
  assign dst = addr[MAP_LSB +: ni_pkg::ID_W];
endmodule

// File: rtl/ni_tx_packer.sv
`timescale 1ns/1ps
module ni_tx_packer
  import ni_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TYPE_W  = 4,
  parameter int PROT_W  = 3,
  parameter int FLIT_W  = 32,
  parameter int NODE_ID = 0,
  parameter int MAP_LSB = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [TYPE_W-1:0] in_type,
  input  logic [PROT_W-1:0] in_prot,
  input  logic [ID_W-1:0]   in_tid,
  output logic              tx_flit_valid,
  input  logic              tx_flit_ready,
  output logic [FLIT_W-1:0] tx_flit,
  output logic              tx_bop,
  output logic              tx_eop
);
  localparam int PAY_W  = ADDR_W + TYPE_W + PROT_W;
  localparam int NPAY   = (PAY_W + FLIT_W - 1) / FLIT_W;
  localparam int NFLIT  = NPAY + 1;
  localparam int CNT_W  = $clog2(NFLIT);
  localparam int NSLOT  = 1 << CNT_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NFLIT - 1);

  logic                   busy;
  logic [CNT_W-1:0]       idx;
  ni_hdr_t                hdr_q;
  logic [NPAY*FLIT_W-1:0] pay_q;
  logic [NPAY*FLIT_W-1:0] pay_d;
  logic [ID_W-1:0]        dst;
  logic                   accept;
  logic [FLIT_W-1:0]      words [NSLOT];

  ni_dest_map #(.ADDR_W(ADDR_W), .MAP_LSB(MAP_LSB)) u_map (
    .addr (in_addr),
    .dst  (dst)
  );

  assign in_ready = !busy;
  assign accept   = in_valid && !busy;

  // Payload packed low to high: address, opcode, protection, zero pad.
  always_comb begin
    pay_d = '0;
    pay_d[PAY_W-1:0] = {in_prot, in_type, in_addr};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      hdr_q <= '0;
      pay_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      idx   <= '0;
      hdr_q <= '{src: ID_W'(NODE_ID), dst: dst, tid: in_tid};
      pay_q <= pay_d;
    end else if (busy && tx_flit_ready) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_word
    if (g == 0) begin : g_hdr
      assign words[g] = FLIT_W'(hdr_q);
    end else if (g <= NPAY) begin : g_pay
      assign words[g] = pay_q[(g-1)*FLIT_W +: FLIT_W];
    end else begin : g_pad
      assign words[g] = '0;
    end
  end

  assign tx_flit_valid = busy;
  assign tx_flit       = words[idx];
  assign tx_bop        = busy && (idx == '0);
  assign tx_eop        = busy && (idx == LAST);
endmodule

// File: rtl/ni_rx_unpacker.sv
`timescale 1ns/1ps
module ni_rx_unpacker
  import ni_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 4,
  parameter int PROT_W = 3,
  parameter int FLIT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_flit_valid,
  output logic              rx_flit_ready,
  input  logic [FLIT_W-1:0] rx_flit,
  input  logic              rx_bop,
  input  logic              rx_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [TYPE_W-1:0] out_type,
  output logic [PROT_W-1:0] out_prot,
  output logic [ID_W-1:0]   out_tid,
  output logic [ID_W-1:0]   out_src,
  output logic [ID_W-1:0]   out_dst
);
  localparam int PAY_W  = ADDR_W + TYPE_W + PROT_W;
  localparam int NPAY   = (PAY_W + FLIT_W - 1) / FLIT_W;
  localparam int PCNT_W = $clog2(NPAY + 1);
  localparam logic [PCNT_W-1:0] PFULL = PCNT_W'(NPAY);

  logic                   in_pkt;
  logic [PCNT_W-1:0]      idx;
  ni_hdr_t                hdr_q;
  logic                   ovalid_q;
  logic                   take;
  logic                   take_body;
  logic [FLIT_W-1:0]      slot [NPAY];
  logic [NPAY*FLIT_W-1:0] pay_flat;
  logic                   unused_pad;

  assign rx_flit_ready = !ovalid_q;
  assign take          = rx_flit_valid && !ovalid_q;
  assign take_body     = take && !rx_bop && in_pkt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      idx      <= '0;
      hdr_q    <= '0;
      ovalid_q <= 1'b0;
    end else begin
      if (ovalid_q && out_ready) ovalid_q <= 1'b0;
      if (take && rx_bop) begin
        hdr_q  <= ni_hdr_t'(rx_flit[HDR_W-1:0]);
        idx    <= '0;
        in_pkt <= !rx_eop;
        if (rx_eop) ovalid_q <= 1'b1;
      end else if (take_body) begin
        if (idx != PFULL) idx <= idx + 1'b1;
        if (rx_eop) begin
          in_pkt   <= 1'b0;
          ovalid_q <= 1'b1;
        end
      end
    end
  end

  // One register per payload flit; cleared when a new packet begins.
  for (genvar g = 0; g < NPAY; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (take && rx_bop) begin
        slot[g] <= '0;
      end else if (take_body && idx == PCNT_W'(g)) begin
        slot[g] <= rx_flit;
      end
    end
    assign pay_flat[g*FLIT_W +: FLIT_W] = slot[g];
  end

  assign unused_pad = ^pay_flat;

  assign out_valid = ovalid_q;
  assign out_addr  = pay_flat[ADDR_W-1:0];
  assign out_type  = pay_flat[ADDR_W +: TYPE_W];
  assign out_prot  = pay_flat[ADDR_W+TYPE_W +: PROT_W];
  assign out_tid   = hdr_q.tid;
  assign out_src   = hdr_q.src;
  assign out_dst   = hdr_q.dst;
endmodule

// File: rtl/snoop_ni.sv
`timescale 1ns/1ps
module snoop_ni
  import ni_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TYPE_W  = 4,
  parameter int PROT_W  = 3,
  parameter int FLIT_W  = 32,
  parameter int NODE_ID = 0,
  parameter int MAP_LSB = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [TYPE_W-1:0] in_type,
  input  logic [PROT_W-1:0] in_prot,
  input  logic [ID_W-1:0]   in_tid,
  output logic              tx_flit_valid,
  input  logic              tx_flit_ready,
  output logic [FLIT_W-1:0] tx_flit,
  output logic              tx_bop,
  output logic              tx_eop,
  input  logic              rx_flit_valid,
  output logic              rx_flit_ready,
  input  logic [FLIT_W-1:0] rx_flit,
  input  logic              rx_bop,
  input  logic              rx_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [TYPE_W-1:0] out_type,
  output logic [PROT_W-1:0] out_prot,
  output logic [ID_W-1:0]   out_tid,
  output logic [ID_W-1:0]   out_src,
  output logic [ID_W-1:0]   out_dst
);
  ni_tx_packer #(
    .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .PROT_W(PROT_W),
    .FLIT_W(FLIT_W), .NODE_ID(NODE_ID), .MAP_LSB(MAP_LSB)
  ) u_tx (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_addr       (in_addr),
    .in_type       (in_type),
    .in_prot       (in_prot),
    .in_tid        (in_tid),
    .tx_flit_valid (tx_flit_valid),
    .tx_flit_ready (tx_flit_ready),
    .tx_flit       (tx_flit),
    .tx_bop        (tx_bop),
    .tx_eop        (tx_eop)
  );

  ni_rx_unpacker #(
    .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .PROT_W(PROT_W), .FLIT_W(FLIT_W)
  ) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_flit_valid (rx_flit_valid),
    .rx_flit_ready (rx_flit_ready),
    .rx_flit       (rx_flit),
    .rx_bop        (rx_bop),
    .rx_eop        (rx_eop),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_addr      (out_addr),
    .out_type      (out_type),
    .out_prot      (out_prot),
    .out_tid       (out_tid),
    .out_src       (out_src),
    .out_dst       (out_dst)
  );
endmodule

// File: rtl/snoop_ni_checker.sv
`timescale 1ns/1ps
module snoop_ni_checker
  import ni_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TYPE_W  = 4,
  parameter int PROT_W  = 3,
  parameter int FLIT_W  = 32,
  parameter int NODE_ID = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              tx_flit_valid,
  input logic              tx_flit_ready,
  input logic [FLIT_W-1:0] tx_flit,
  input logic              tx_bop,
  input logic              tx_eop,
  input logic              rx_flit_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [TYPE_W-1:0] out_type,
  input logic [PROT_W-1:0] out_prot,
  input logic [ID_W-1:0]   out_tid,
  input logic [ID_W-1:0]   out_src,
  input logic [ID_W-1:0]   out_dst
);
  assert_first_bop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (tx_flit_valid && tx_bop));

  assert_single_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flit_valid |-> !(tx_bop && tx_eop));

  assert_src_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flit_valid && tx_bop) |-> (tx_flit[2*ID_W +: ID_W] == ID_W'(NODE_ID)));

  assert_req_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flit_valid |-> !in_ready);

  assert_flit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flit_valid && !tx_flit_ready) |=>
      (tx_flit_valid && $stable(tx_flit) && $stable(tx_bop) && $stable(tx_eop)));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_addr) && $stable(out_type) && $stable(out_prot)
       && $stable(out_tid) && $stable(out_src) && $stable(out_dst)));

  assert_rx_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rx_flit_ready);

  assert_out_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
endmodule

bind snoop_ni snoop_ni_checker #(
  .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .PROT_W(PROT_W),
  .FLIT_W(FLIT_W), .NODE_ID(NODE_ID)
) u_chk (.*);

// File: tb/snoop_ni_test.sv
`timescale 1ns/1ps
module snoop_ni_test;
  localparam int NODE = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [3:0]  in_type = '0;
  logic [2:0]  in_prot = '0;
  logic [3:0]  in_tid = '0;
  logic        tx_flit_valid;
  logic        tx_flit_ready = 1'b0;
  logic [31:0] tx_flit;
  logic        tx_bop, tx_eop;
  logic        rx_flit_valid = 1'b0;
  logic        rx_flit_ready;
  logic [31:0] rx_flit = '0;
  logic        rx_bop = 1'b0, rx_eop = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_addr;
  logic [3:0]  out_type;
  logic [2:0]  out_prot;
  logic [3:0]  out_tid, out_src, out_dst;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [31:0] cap [3];

  always #2.5 clk = ~clk;

  snoop_ni #(.NODE_ID(NODE)) uut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_flit(input int k, input logic [31:0] a,
      input logic [3:0] ty, input logic [2:0] pr, input logic [3:0] id);
    if (k == 0)      return {20'h0, 4'(NODE), a[31:28], id};
    else if (k == 1) return a;
    else             return {25'h0, pr, ty};
  endfunction

  // Send one request and capture its flits, stalling the router per seed.
  task automatic tx_run(input logic [31:0] a, input logic [3:0] ty,
                        input logic [2:0] pr, input logic [3:0] id, input int seed);
    check(in_ready == 1'b1, "R6 idle ready", 64'(in_ready), 64'd1);
    in_valid = 1'b1; in_addr = a; in_type = ty; in_prot = pr; in_tid = id;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      logic [31:0] e;
      e = exp_flit(k, a, ty, pr, id);
      check(tx_flit_valid && tx_flit == e, (k == 0) ? "R3 header flit" : "R5 payload flit",
            64'(tx_flit), 64'(e));
      check(tx_bop == (k == 0) && tx_eop == (k == 2), "R2 markers",
            {62'd0, tx_bop, tx_eop}, {62'd0, k == 0, k == 2});
      check(in_ready == 1'b0, "R6 busy ready", 64'(in_ready), 64'd0);
      repeat ((seed + k) % 3) begin
        tx_flit_ready = 1'b0;
        @(negedge clk);
        check(tx_flit_valid && tx_flit == e, "R7 stalled flit", 64'(tx_flit), 64'(e));
      end
      tx_flit_ready = 1'b1;
      cap[k] = tx_flit;
      @(negedge clk);
      tx_flit_ready = 1'b0;
    end
    check(cap[0][7:4] == a[31:28], "R4 destination", 64'(cap[0][7:4]), 64'(a[31:28]));
    check(!tx_flit_valid && in_ready, "R6 ready back",
          {62'd0, tx_flit_valid, in_ready}, 64'd1);
  endtask

  task automatic rx_push(input logic [31:0] d, input logic b, input logic e);
    while (!rx_flit_ready) @(negedge clk);
    rx_flit_valid = 1'b1; rx_flit = d; rx_bop = b; rx_eop = e;
    @(negedge clk);
    rx_flit_valid = 1'b0; rx_bop = 1'b0; rx_eop = 1'b0;
  endtask

  task automatic rx_expect(input string req, input logic [31:0] a, input logic [3:0] ty,
      input logic [2:0] pr, input logic [3:0] id, input logic [3:0] s, input logic [3:0] d);
    logic [50:0] act, exp;
    exp = {a, ty, pr, id, s, d};
    for (int h = 0; h < 3; h++) begin
      act = {out_addr, out_type, out_prot, out_tid, out_src, out_dst};
      check(out_valid && act == exp, req, 64'(act), 64'(exp));
      if (h > 0) check(rx_flit_ready == 1'b0, "R9 rx blocked", 64'(rx_flit_ready), 64'd0);
      if (h < 2) @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && rx_flit_ready, "R9 release", {62'd0, out_valid, rx_flit_ready}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready && rx_flit_ready && !tx_flit_valid && !out_valid, "R1 reset state",
          {60'd0, in_ready, rx_flit_ready, tx_flit_valid, out_valid}, 64'hC);
    rst_n = 1'b1;
    @(negedge clk);

    for (int id = 0; id < 16; id++) begin
      for (int dn = 0; dn < 16; dn++) begin
        logic [31:0] a;
        logic [3:0]  ty;
        logic [2:0]  pr;
        a  = {4'(dn), 28'(id * 32'h0123457 + dn * 32'h009abcd)};
        ty = 4'((id + 3 * dn) % 16);
        pr = 3'((id * 3 + dn) % 8);
        tx_run(a, ty, pr, 4'(id), id + dn);
        rx_push(cap[0], 1'b1, 1'b0);
        rx_push(cap[1], 1'b0, 1'b0);
        rx_push(cap[2], 1'b0, 1'b1);
        rx_expect("R8 rebuilt fields", a, ty, pr, 4'(id), 4'(NODE), 4'(dn));
      end
    end

    // R10: stray flits before any begin marker are dropped.
    rx_push(32'hDEAD_BEEF, 1'b0, 1'b0);
    rx_push(32'h0000_0077, 1'b0, 1'b1);
    check(!out_valid, "R10 stray dropped", 64'(out_valid), 64'd0);
    rx_push({20'h0, 4'h3, 4'hA, 4'h6}, 1'b1, 1'b0);
    rx_push(32'hA123_4567, 1'b0, 1'b0);
    rx_push({25'h0, 3'd2, 4'h9}, 1'b0, 1'b1);
    rx_expect("R10 next packet intact", 32'hA123_4567, 4'h9, 3'd2, 4'h6, 4'h3, 4'hA);

    // R11: a begin marker mid-packet restarts assembly.
    rx_push({20'h0, 4'h1, 4'h2, 4'h3}, 1'b1, 1'b0);
    rx_push(32'h1111_1111, 1'b0, 1'b0);
    check(!out_valid, "R11 partial not shown", 64'(out_valid), 64'd0);
    rx_push({20'h0, 4'h7, 4'h2, 4'h9}, 1'b1, 1'b0);
    rx_push(32'h2BCD_EF01, 1'b0, 1'b0);
    rx_push({25'h0, 3'd5, 4'hC}, 1'b0, 1'b1);
    rx_expect("R11 restarted packet", 32'h2BCD_EF01, 4'hC, 3'd5, 4'h9, 4'h7, 4'h2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule